// File: doc/BRIEF.md
# Extended-Precision Value Classifier

This block sorts 80-bit extended-precision values (one sign bit, a 15-bit exponent and a 64-bit significand whose top bit is an explicit integer bit) into classes. For a single value it produces, with no clock delay, a 4-bit examine code in the condition bits C3..C0 and a 2-bit tag. It does no arithmetic.

A second, sequential path walks a register file of eight entries, together with one empty flag per entry. It takes one entry per clock and builds two results: a 16-bit tag word holding two bits per entry, and an abridged 8-bit byte holding one presence bit per entry. It pulses a done strobe once the last entry has been written. The register file and the empty flags must stay stable while the walk is busy.

Top module: `xpc_classifier`

## Requirements
- R1: Bit 1 of `exam_cc` (C1) equals the sign bit `exam_value[79]` for every input, including empty.
- R2: When `exam_empty` is 1, `exam_cc` reports the empty code: C3=1, C2=0 and C0=1 (bits 3, 2 and 0), whatever the value. `exam_tag` is 2'b11.
- R3: With exponent `exam_value[78:64]` equal to 0x7FFF, a significand of exactly 0x8000_0000_0000_0000 gives infinity (C3=0, C2=1, C0=1). Any other significand gives NaN (C3=0, C2=0, C0=1).
- R4: With exponent 0, a zero significand gives zero (C3=1, C2=0, C0=0). A nonzero significand gives denormal (C3=1, C2=1, C0=0).
- R5: Any other exponent gives normal (C3=0, C2=1, C0=0), whether or not the integer bit 63 is set.
- R6: For a non-empty value, `exam_tag` is 2'b01 for zero. It is 2'b10 for a special value: exponent 0 with a nonzero significand, exponent 0x7FFF, or integer bit 63 clear. It is 2'b00 otherwise.
- R7: After a walk, `tag_word[2i+1:2i]` holds the R2/R6 tag of entry i, where entry i is `reg_values[80i+79:80i]` with empty flag `reg_empty[i]`.
- R8: After a walk, `tag_abridged[i]` is 1 exactly when `reg_empty[i]` is 0.
- R9: A `walk_start` seen while idle sets `walk_busy` at the next edge. `walk_done` then rises for exactly one cycle, 8 cycles later, as `walk_busy` falls. `walk_start` is ignored while busy.
- R10: After reset, `tag_word` is 16'hFFFF, `tag_abridged` is 0, and `walk_busy` and `walk_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exam_value | input | 80 | Value to classify |
| exam_empty | input | 1 | The examined entry is empty |
| exam_cc | output | 4 | Examine code {C3,C2,C1,C0} |
| exam_tag | output | 2 | Tag of the examined value |
| walk_start | input | 1 | Begin a tag-word walk |
| reg_values | input | 640 | Eight entries, entry i at bits 80i+79:80i |
| reg_empty | input | 8 | Empty flag per entry |
| walk_busy | output | 1 | Walk in progress |
| walk_done | output | 1 | One-cycle pulse when the walk ends |
| tag_word | output | 16 | Two-bit tag per entry |
| tag_abridged | output | 8 | One presence bit per entry |

## Verification
The examine path is swept over every combination of five exponents (0, 1, mid-range, one below the maximum, and the maximum) and five significands (zero, one, the lone integer bit, integer bit plus a fraction bit, and a fraction with the integer bit clear), with both signs and both empty settings. This separates infinity from NaN by a single bit, zero from denormal, and normal from unnormal, where the tag differs but the examine code does not. It also shows that empty overrides every class while C1 still follows the sign. The walk is run with rotating mixes of these values under several empty patterns. A stray start pulse issued mid-walk checks that the entry positions and the done timing hold.

// File: rtl/xpc_classifier.sv
module xpc_classifier #(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter int ENTRIES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [EXP_W+MAN_W:0]       exam_value,
  input  logic                       exam_empty,
  output logic [3:0]                 exam_cc,
  output logic [1:0]                 exam_tag,
  input  logic                       walk_start,
  input  logic [ENTRIES*(EXP_W+MAN_W+1)-1:0] reg_values,
  input  logic [ENTRIES-1:0]         reg_empty,
  output logic                       walk_busy,
  output logic                       walk_done,
  output logic [2*ENTRIES-1:0]       tag_word,
  output logic [ENTRIES-1:0]         tag_abridged
);
  localparam int VAL_W = 1 + EXP_W + MAN_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);
  localparam logic [EXP_W-1:0] EXP_MAX = '1;
  localparam logic [MAN_W-1:0] MAN_INF = {1'b1, {(MAN_W-1){1'b0}}};

  function automatic logic [1:0] tag_of(input logic [VAL_W-1:0] v, input logic empty);
    logic [EXP_W-1:0] e;
    logic [MAN_W-1:0] m;
    e = v[VAL_W-2 -: EXP_W];
    m = v[MAN_W-1:0];
    if (empty)                                     return 2'b11;
    else if (e == '0 && m == '0)                   return 2'b01;
    else if (e == '0 || e == EXP_MAX || !m[MAN_W-1]) return 2'b10;
    else                                           return 2'b00;
  endfunction

  wire [EXP_W-1:0] ex_exp = exam_value[VAL_W-2 -: EXP_W];
  wire [MAN_W-1:0] ex_man = exam_value[MAN_W-1:0];
  wire             ex_sgn = exam_value[VAL_W-1];

  logic [2:0] c320;
  always_comb begin
    if (exam_empty)            c320 = 3'b101;
    else if (ex_exp == EXP_MAX) c320 = (ex_man == MAN_INF) ? 3'b011 : 3'b001;
    else if (ex_exp == '0)      c320 = (ex_man == '0) ? 3'b100 : 3'b110;
    else                        c320 = 3'b010;
  end

  assign exam_cc  = {c320[2], c320[1], ex_sgn, c320[0]};
  assign exam_tag = tag_of(exam_value, exam_empty);

  logic [IDX_W-1:0] idx;
  wire  [VAL_W-1:0] walk_val = reg_values[int'(idx)*VAL_W +: VAL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      walk_busy    <= 1'b0;
      walk_done    <= 1'b0;
      idx          <= '0;
      tag_word     <= '1;
      tag_abridged <= '0;
    end else begin
      walk_done <= 1'b0;
      if (walk_busy) begin
        tag_word[2*int'(idx) +: 2] <= tag_of(walk_val, reg_empty[idx]);
        tag_abridged[idx]          <= ~reg_empty[idx];
        if (idx == LAST) begin
          walk_busy <= 1'b0;
          walk_done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end else if (walk_start) begin
        walk_busy <= 1'b1;
        idx       <= '0;
      end
    end
  end
endmodule

// File: rtl/xpc_classifier_chk.sv
module xpc_classifier_chk #(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter int ENTRIES = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [EXP_W+MAN_W:0]       exam_value,
  input logic                       exam_empty,
  input logic [3:0]                 exam_cc,
  input logic [1:0]                 exam_tag,
  input logic                       walk_busy,
  input logic                       walk_done
);
  localparam int CNT_W = $clog2(ENTRIES + 2);
  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         busy_cnt <= '0;
    else if (walk_busy) busy_cnt <= busy_cnt + 1'b1;
    else                busy_cnt <= '0;

  p_sign_mirror_r1: assert property (@(posedge clk) disable iff (!rst_n)
    exam_cc[1] == exam_value[EXP_W+MAN_W]);
  p_empty_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
    exam_empty |-> (exam_cc[3] && !exam_cc[2] && exam_cc[0] && exam_tag == 2'b11));
  p_top_exp_special_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!exam_empty && &exam_value[EXP_W+MAN_W-1:MAN_W]) |-> (exam_cc[0] && !exam_cc[3] && exam_tag == 2'b10));
  p_zero_exp_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!exam_empty && exam_value[EXP_W+MAN_W-1:MAN_W] == '0) |-> (exam_cc[3] && !exam_cc[0]));
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);
  p_done_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (!walk_busy && busy_cnt == CNT_W'(ENTRIES)));
endmodule

bind xpc_classifier xpc_classifier_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .exam_value(exam_value), .exam_empty(exam_empty),
  .exam_cc(exam_cc), .exam_tag(exam_tag), .walk_busy(walk_busy), .walk_done(walk_done)
);

// File: tb/xpc_classifier_bench.sv
module xpc_classifier_bench;
  logic          clk = 0;
  logic          rst_n = 0;
  logic [79:0]   exam_value = '0;
  logic          exam_empty = 0;
  logic [3:0]    exam_cc;
  logic [1:0]    exam_tag;
  logic          walk_start = 0;
  logic [639:0]  reg_values = '0;
  logic [7:0]    reg_empty = '0;
  logic          walk_busy, walk_done;
  logic [15:0]   tag_word;
  logic [7:0]    tag_abridged;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  xpc_classifier u_xpc_classifier (.*);

  logic [14:0] exps [5] = '{15'h0000, 15'h0001, 15'h3FFF, 15'h7FFE, 15'h7FFF};
  logic [63:0] mans [5] = '{64'h0, 64'h1, 64'h8000_0000_0000_0000,
                            64'hC000_0000_0000_0000, 64'h4000_0000_0000_0001};

  function automatic logic [3:0] want_cc(logic [79:0] v, logic emp);
    logic [2:0] c;
    if (emp) c = 3'b101;
    else if (v[78:64] == 15'h7FFF) c = (v[63:0] == 64'h8000_0000_0000_0000) ? 3'b011 : 3'b001;
    else if (v[78:64] == 0) c = (v[63:0] == 0) ? 3'b100 : 3'b110;
    else c = 3'b010;
    return {c[2], c[1], v[79], c[0]};
  endfunction

  function automatic logic [1:0] want_tag(logic [79:0] v, logic emp);
    if (emp) return 2'b11;
    if (v[78:64] == 0 && v[63:0] == 0) return 2'b01;
    if (v[78:64] == 0 || v[78:64] == 15'h7FFF || !v[63]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_walk(logic stray);
    int cycles = 0;
    logic [15:0] w = '0;
    logic [7:0]  a = '0;
    for (int i = 0; i < 8; i++) begin
      w[2*i +: 2] = want_tag(reg_values[80*i +: 80], reg_empty[i]);
      a[i] = ~reg_empty[i];
    end
    @(negedge clk); walk_start = 1;
    @(negedge clk); walk_start = 0;
    check("R9 busy", {31'b0, walk_busy}, 1);
    while (!walk_done && cycles < 20) begin
      @(negedge clk); cycles++;
      if (stray && cycles == 3) walk_start = 1;
      else walk_start = 0;
    end
    walk_start = 0;
    check("R9 latency", cycles, 8);
    check("R9 busy low at done", {31'b0, walk_busy}, 0);
    check("R7 tag word", {16'b0, tag_word}, {16'b0, w});
    check("R8 abridged", {24'b0, tag_abridged}, {24'b0, a});
    @(negedge clk);
    check("R9 done pulse", {31'b0, walk_done}, 0);
    check("R9 stays idle", {31'b0, walk_busy}, 0);
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 tag word reset", {16'b0, tag_word}, 32'hFFFF);
    check("R10 abridged reset", {24'b0, tag_abridged}, 0);
    check("R10 busy/done reset", {30'b0, walk_busy, walk_done}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int e = 0; e < 5; e++)
      for (int m = 0; m < 5; m++)
        for (int s = 0; s < 2; s++)
          for (int em = 0; em < 2; em++) begin
            exam_value = {s[0], exps[e], mans[m]};
            exam_empty = em[0];
            @(negedge clk);
            check(em ? "R2 empty code" : (exps[e] == 15'h7FFF ? "R3 top exponent"
                  : (exps[e] == 0 ? "R4 zero exponent" : "R5 normal")),
                  {28'b0, exam_cc}, {28'b0, want_cc(exam_value, exam_empty)});
            check("R1 sign", {31'b0, exam_cc[1]}, {31'b0, s[0]});
            check("R6 tag", {30'b0, exam_tag}, {30'b0, want_tag(exam_value, exam_empty)});
          end

    for (int p = 0; p < 6; p++) begin
      for (int i = 0; i < 8; i++) begin
        int k = (p * 3 + i) % 25;
        reg_values[80*i +: 80] = {(i % 2 == 1), exps[k / 5], mans[k % 5]};
      end
      reg_empty = (8'hA5 << p) | (8'h81 >> p);
      if (p == 5) reg_empty = 8'h00;
      run_walk(p == 2 || p == 4);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule